// File: doc/BRIEF.md
# Multicycle Shared-ALU Processor Datapath

This block is the datapath half of a 32-bit load/store processor that spends several clock cycles on each instruction. A single ALU does every piece of arithmetic the machine needs. It advances the program counter, forms branch targets, forms load/store addresses and executes register-to-register operations. Which of these it does in a given cycle depends only on how its two operand multiplexers are steered. In the same way, one memory port serves both instruction fetch and data access, and an address select chooses between the program counter and the latched ALU result.

Intermediate results move from cycle to cycle through internal registers:

- a program counter;
- an instruction register;
- two operand latches;
- an ALU result latch;
- a memory data latch.

Every multiplexer select and every write enable is an input port driven by an external sequencing controller. The datapath returns the opcode, the function field and the ALU zero flag to that controller. The unified memory sits outside the block. The block presents the address, write data and both access strobes, and it accepts the read data as a combinational return of the presented address.

Top module: `mc_datapath`

## Requirements
- R1: After reset the program counter is 0 and the instruction register is 0, so the memory address (address select 0) reads 0 and the opcode and function outputs read 0.
- R2: With address select 0 the memory address equals the program counter. The program counter changes only on a clock edge where `pc_we` is high. With `pc_src_sel` 0 it loads the live ALU result, so a cycle using PC plus the constant 4 advances it by 4.
- R3: The instruction register loads the memory read data only on an edge where `ir_we` is high and otherwise keeps its word, even if the memory data at the program counter changes.
- R4: ALU operand A is the program counter when `src_a_sel` is 0 and operand latch A when it is 1. Operand B is selected by `src_b_sel`: 00 gives operand latch B, 01 gives the constant 4, 10 gives the sign-extended 16-bit immediate (bits 15-0), and 11 gives that value shifted left by 2.
- R5: The ALU code `alu_ctl` selects the operation: 000 AND, 001 OR, 010 add, 110 subtract, 111 signed set-less-than (result 1 or 0). `alu_zero` is high exactly when the live ALU result is zero, so subtraction tests equality.
- R6: With address select 1 the memory address is the ALU result latch. `mem_wdata` is operand latch B. `mem_re` and `mem_we` follow `mem_rd_en` and `mem_wr_en`.
- R7: The register file reads rs from bits 25-21 and rt from bits 20-16. It writes on an edge with `rf_we` high. The destination is rt when `dst_sel` is 0 and rd (bits 15-11) when it is 1. The write data is the ALU result latch when `wb_sel` is 0 and the memory data latch when it is 1.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: With `pc_src_sel` 1 a program-counter load takes the ALU result latch. After a target cycle (operand A = PC, operand B = shifted immediate) this branches to PC+4 plus the offset times 4, for both positive and negative offsets.
- R10: `opcode` is instruction bits 31-26 and `funct` is instruction bits 5-0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_we | input | 1 | Program counter load enable |
| pc_src_sel | input | 1 | PC source: 0 live ALU result, 1 ALU result latch |
| ir_we | input | 1 | Instruction register load enable |
| addr_sel | input | 1 | Memory address: 0 program counter, 1 ALU result latch |
| src_a_sel | input | 1 | ALU operand A select |
| src_b_sel | input | 2 | ALU operand B select |
| alu_ctl | input | 3 | ALU operation code |
| rf_we | input | 1 | Register file write enable |
| dst_sel | input | 1 | Write destination: 0 rt, 1 rd |
| wb_sel | input | 1 | Write data: 0 ALU result latch, 1 memory data latch |
| mem_rd_en | input | 1 | Memory read request from controller |
| mem_wr_en | input | 1 | Memory write request from controller |
| mem_rdata | input | 32 | Memory read data for the presented address |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data (operand latch B) |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| opcode | output | 6 | Instruction bits 31-26 |
| funct | output | 6 | Instruction bits 5-0 |
| alu_zero | output | 1 | Live ALU result is zero |

## Verification
The bench builds the block with the default of 32 registers. At that size the 5-bit register fields decode directly, so destination registers 1 through 10 are reachable by real instruction encodings and the fixed-zero register can be hit on purpose.

With the default 32-bit word, the bench can reach several boundary cases:

- an add that wraps to zero;
- a signed compare of a negative against a positive;
- a negative load/store offset;
- branch offsets in both directions that only work if the immediate is sign-extended.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int DW     = 32;
    localparam int IMM_W  = 16;
    localparam int FLD_W  = 5;
    localparam int OPC_W  = 6;

    localparam int OPC_LSB = 26;
    localparam int RS_LSB  = 21;
    localparam int RT_LSB  = 16;
    localparam int RD_LSB  = 11;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        SRCB_REG  = 2'b00,
        SRCB_FOUR = 2'b01,
        SRCB_IMM  = 2'b10,
        SRCB_IMM4 = 2'b11
    } srcb_e;

    typedef struct packed {
        logic [DW-1:0] pc;
        logic [DW-1:0] ir;
        logic [DW-1:0] opa;
        logic [DW-1:0] opb;
        logic [DW-1:0] res;
        logic [DW-1:0] mdat;
    } dp_state_t;
endpackage

// File: rtl/mc_opsel.sv
module mc_opsel
    import mc_pkg::*;
(
    input  logic [DW-1:0]    pc,
    input  logic [DW-1:0]    opa_lat,
    input  logic [DW-1:0]    opb_lat,
    input  logic [IMM_W-1:0] imm,
    input  logic             src_a_sel,
    input  logic [1:0]       src_b_sel,
    output logic [DW-1:0]    alu_a,
    output logic [DW-1:0]    alu_b
);
    localparam int EXT_W = DW - IMM_W;

    logic [DW-1:0] imm_sx;
    logic [DW-1:0] imm_sx4;

    always_comb begin
        imm_sx  = {{EXT_W{imm[IMM_W-1]}}, imm};
        imm_sx4 = {imm_sx[DW-3:0], 2'b00};
        alu_a   = src_a_sel ? opa_lat : pc;
        unique case (srcb_e'(src_b_sel))
            SRCB_REG:  alu_b = opb_lat;
            SRCB_FOUR: alu_b = DW'(4);
            SRCB_IMM:  alu_b = imm_sx;
            SRCB_IMM4: alu_b = imm_sx4;
            default:   alu_b = opb_lat;
        endcase
    end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [2:0]    ctl,
    output logic [DW-1:0] y,
    output logic          zero
);
    logic lt;

    always_comb begin
        lt = $signed(a) < $signed(b);
        case (alu_op_e'(ctl))
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(DW-1){1'b0}}, lt};
            default: y = '0;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd1,
    output logic [DW-1:0] rd2
);
    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];

    // R8: the fixed-zero register reads zero on both ports
    assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ra1 == '0) |-> (rd1 == '0)) and ((ra2 == '0) |-> (rd2 == '0)));
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int NREG = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pc_we,
    input  logic          pc_src_sel,
    input  logic          ir_we,
    input  logic          addr_sel,
    input  logic          src_a_sel,
    input  logic [1:0]    src_b_sel,
    input  logic [2:0]    alu_ctl,
    input  logic          rf_we,
    input  logic          dst_sel,
    input  logic          wb_sel,
    input  logic          mem_rd_en,
    input  logic          mem_wr_en,
    input  logic [31:0]   mem_rdata,
    output logic [31:0]   mem_addr,
    output logic [31:0]   mem_wdata,
    output logic          mem_re,
    output logic          mem_we,
    output logic [5:0]    opcode,
    output logic [5:0]    funct,
    output logic          alu_zero
);
    localparam int RAW = $clog2(NREG);

    dp_state_t st_q, st_d;

    logic [DW-1:0]  rf_rd1, rf_rd2;
    logic [DW-1:0]  alu_a, alu_b, alu_y;
    logic [DW-1:0]  wb_data;
    logic [RAW-1:0] wr_idx;
    logic           alu_z;

    mc_opsel u_opsel (
        .pc        (st_q.pc),
        .opa_lat   (st_q.opa),
        .opb_lat   (st_q.opb),
        .imm       (st_q.ir[IMM_W-1:0]),
        .src_a_sel (src_a_sel),
        .src_b_sel (src_b_sel),
        .alu_a     (alu_a),
        .alu_b     (alu_b)
    );

    mc_alu u_alu (
        .a    (alu_a),
        .b    (alu_b),
        .ctl  (alu_ctl),
        .y    (alu_y),
        .zero (alu_z)
    );

    mc_regfile #(.NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .ra1   (st_q.ir[RS_LSB +: RAW]),
        .ra2   (st_q.ir[RT_LSB +: RAW]),
        .wa    (wr_idx),
        .wd    (wb_data),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2)
    );

    always_comb begin
        wr_idx  = dst_sel ? st_q.ir[RD_LSB +: RAW] : st_q.ir[RT_LSB +: RAW];
        wb_data = wb_sel ? st_q.mdat : st_q.res;

        st_d      = st_q;
        st_d.opa  = rf_rd1;
        st_d.opb  = rf_rd2;
        st_d.res  = alu_y;
        st_d.mdat = mem_rdata;
        if (ir_we) begin
            st_d.ir = mem_rdata;
        end
        if (pc_we) begin
            st_d.pc = pc_src_sel ? st_q.res : alu_y;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = addr_sel ? st_q.res : st_q.pc;
    assign mem_wdata = st_q.opb;
    assign mem_re    = mem_rd_en;
    assign mem_we    = mem_wr_en;
    assign opcode    = st_q.ir[OPC_LSB +: OPC_W];
    assign funct     = st_q.ir[5:0];
    assign alu_zero  = alu_z;

    // R2: the program counter only moves after an enabled edge
    assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pc_we) |-> $stable(st_q.pc));

    // R3: the instruction word is kept while its load enable is low
    assert_ir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ir_we) |-> $stable(st_q.ir));

    // R9: a latched-source load copies the previous ALU result latch
    assert_pc_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pc_we && pc_src_sel) |-> (st_q.pc == $past(st_q.res)));

    // R5: on subtraction the zero flag reports operand equality
    assert_sub_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_ctl == ALU_SUB) |-> (alu_zero == (alu_a == alu_b)));
endmodule

// File: tb/sim_mc_datapath.sv
`timescale 1ns/1ps
module sim_mc_datapath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_we, pc_src_sel, ir_we, addr_sel, src_a_sel;
    logic [1:0]  src_b_sel;
    logic [2:0]  alu_ctl;
    logic        rf_we, dst_sel, wb_sel, mem_rd_en, mem_wr_en;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic        mem_re, mem_we, alu_zero;
    logic [5:0]  opcode, funct;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_pc;
    logic [31:0] mem [0:255];

    always #4 clk = ~clk;

    mc_datapath u0 (
        .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .pc_src_sel(pc_src_sel),
        .ir_we(ir_we), .addr_sel(addr_sel), .src_a_sel(src_a_sel),
        .src_b_sel(src_b_sel), .alu_ctl(alu_ctl), .rf_we(rf_we),
        .dst_sel(dst_sel), .wb_sel(wb_sel), .mem_rd_en(mem_rd_en),
        .mem_wr_en(mem_wr_en), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_we(mem_we),
        .opcode(opcode), .funct(funct), .alu_zero(alu_zero)
    );

    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

    // ctl, funct, a, b, expected
    localparam logic [104:0] VEC [0:7] = '{
        {3'b010, 6'h20, 32'd5,         32'd7,         32'd12},
        {3'b010, 6'h20, 32'hFFFF_FFFF, 32'd1,         32'd0},
        {3'b110, 6'h22, 32'd10,        32'd3,         32'd7},
        {3'b110, 6'h22, 32'd3,         32'd10,        32'hFFFF_FFF9},
        {3'b000, 6'h24, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h00F0_000F},
        {3'b001, 6'h25, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFFF0_0FFF},
        {3'b111, 6'h2A, 32'hFFFF_FFFF, 32'd1,         32'd1},
        {3'b111, 6'h2A, 32'd5,         32'hFFFF_FFFD, 32'd0}
    };

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        pc_we = 0; pc_src_sel = 0; ir_we = 0; addr_sel = 0; src_a_sel = 0;
        src_b_sel = 2'b00; alu_ctl = 3'b010; rf_we = 0; dst_sel = 0;
        wb_sel = 0; mem_rd_en = 0; mem_wr_en = 0;
    endtask

    task automatic st_fetch();
        idle();
        addr_sel = 0; mem_rd_en = 1; ir_we = 1; src_a_sel = 0;
        src_b_sel = 2'b01; alu_ctl = 3'b010; pc_we = 1;
        #1 chk("R2", "fetch address", mem_addr, exp_pc);
        chk("R6", "read strobe", 32'(mem_re), 32'd1);
        @(negedge clk);
        exp_pc = exp_pc + 4;
        idle();
    endtask

    task automatic st_decode();
        idle();
        src_a_sel = 0; src_b_sel = 2'b11; alu_ctl = 3'b010;
        @(negedge clk); idle();
    endtask

    task automatic st_addr();
        idle();
        src_a_sel = 1; src_b_sel = 2'b10; alu_ctl = 3'b010;
        @(negedge clk); idle();
    endtask

    task automatic run_lw(input int rt, input int rs, input logic [15:0] imm);
        mem[exp_pc[9:2]] = enc_i(6'h23, rs, rt, imm);
        st_fetch();
        chk("R10", "lw opcode", 32'(opcode), 32'h23);
        st_decode();
        st_addr();
        addr_sel = 1; mem_rd_en = 1;
        @(negedge clk); idle();
        rf_we = 1; dst_sel = 0; wb_sel = 1;
        @(negedge clk); idle();
    endtask

    task automatic run_sw(input int rt, input int rs, input logic [15:0] imm,
                          input logic [31:0] exp_addr, input logic [31:0] exp_data,
                          input string req);
        mem[exp_pc[9:2]] = enc_i(6'h2B, rs, rt, imm);
        st_fetch();
        mem[exp_pc[9:2]] = 32'hFFFF_FFFF;
        st_decode();
        chk("R3", "ir held over changed memory", 32'(opcode), 32'h2B);
        st_addr();
        addr_sel = 1; mem_wr_en = 1;
        #1 chk("R6", "store address", mem_addr, exp_addr);
        chk(req, "store data", mem_wdata, exp_data);
        chk("R6", "write strobe", 32'(mem_we), 32'd1);
        @(negedge clk); idle();
        chk("R6", "memory word after store", mem[exp_addr[9:2]], exp_data);
    endtask

    task automatic run_r(input int rs, input int rt, input int rd,
                         input logic [2:0] ctl, input logic [5:0] fn);
        mem[exp_pc[9:2]] = enc_r(rs, rt, rd, fn);
        st_fetch();
        chk("R10", "r-type opcode", 32'(opcode), 32'h00);
        chk("R10", "r-type funct", 32'(funct), 32'(fn));
        st_decode();
        src_a_sel = 1; src_b_sel = 2'b00; alu_ctl = ctl;
        @(negedge clk); idle();
        rf_we = 1; dst_sel = 1; wb_sel = 0;
        @(negedge clk); idle();
    endtask

    task automatic run_beq(input int rs, input int rt, input logic [15:0] off,
                           input logic exp_taken);
        mem[exp_pc[9:2]] = enc_i(6'h04, rs, rt, off);
        st_fetch();
        st_decode();
        src_a_sel = 1; src_b_sel = 2'b00; alu_ctl = 3'b110; pc_src_sel = 1;
        #1 chk("R5", "branch zero flag", 32'(alu_zero), 32'(exp_taken));
        pc_we = alu_zero;
        @(negedge clk); idle();
        if (exp_taken) exp_pc = exp_pc + {{14{off[15]}}, off, 2'b00};
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        idle();
        exp_pc = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk("R1", "reset pc", mem_addr, 32'h0);
        chk("R1", "reset opcode", 32'(opcode), 32'h0);
        chk("R1", "reset funct", 32'(funct), 32'h0);
        @(negedge clk);

        // Table walk: two loads, one operation, one store per vector
        for (int i = 0; i < 8; i++) begin
            logic [104:0] v;
            v = VEC[i];
            mem[192] = v[95:64];
            mem[193] = v[63:32];
            run_lw(1, 0, 16'h0300);
            run_lw(2, 0, 16'h0304);
            run_r(1, 2, 3 + i, v[104:102], v[101:96]);
            run_sw(3 + i, 0, 16'h0308, 32'h308, v[31:0], "R5");
        end

        // R8: writing register 0 has no effect
        run_lw(0, 0, 16'h0300);
        run_sw(0, 0, 16'h030C, 32'h30C, 32'h0, "R8");

        // R7: r-type writes rd, leaving rt with its loaded value
        run_sw(2, 0, 16'h030C, 32'h30C, 32'hFFFF_FFFD, "R7");

        // R9: forward taken, not taken, backward taken
        mem[192] = 32'd42;
        mem[193] = 32'd42;
        mem[194] = 32'd7;
        run_lw(1, 0, 16'h0300);
        run_lw(2, 0, 16'h0304);
        run_beq(1, 2, 16'd3, 1'b1);
        run_lw(2, 0, 16'h0308);
        run_beq(1, 2, 16'd5, 1'b0);
        run_beq(0, 0, 16'hFFFA, 1'b1);

        // R4: negative immediate on effective address
        mem[193] = 32'h0000_0310;
        run_lw(6, 0, 16'h0304);
        run_sw(1, 6, 16'hFFFC, 32'h30C, 32'd42, "R4");

        // R2: pc stays put with its enable low
        repeat (3) @(negedge clk);
        #1 chk("R2", "pc held while idle", mem_addr, exp_pc);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule